// File: doc/BRIEF.md
# Atomic 64-bit Compare-Exchange Unit

This unit carries out one 64-bit compare-and-swap against a single memory word. The request gives the word address, an expected value and a replacement value (each split into a high and a low 32-bit half), a lock flag, an intercept-enable bit and an external-lock-required indication. The unit runs a read-modify-write on a simple valid/ready bus master port. It reads the word, compares it with the expected value, and then always writes the word back.

On a match the replacement goes to memory and the equal flag is set. On a mismatch the word just read is written back unchanged, the word is returned in the expected-value halves, and the equal flag is cleared. When the lock flag is set, the lock output covers the read, the compare and the write.

If an external atomic lock would be needed and interception is enabled, the unit starts no bus cycle. It finishes at once with a fault indication and leaves the returned halves and the equal flag as they were.

The controller moves through IDLE, READ, COMPARE, WRITE and DONE. The named transitions are:
- accept: IDLE to READ, when a request is taken with no intercept.
- intercept: IDLE to DONE, when a request is taken with the intercept condition true.
- read-ack: READ to COMPARE.
- decide: COMPARE to WRITE.
- write-ack: WRITE to DONE.
- retire: DONE to IDLE.

Top module: `cas_unit`

## Requirements
- R1: After reset the unit is in IDLE. In IDLE, `req_ready`=1 and `bus_lock`, `rd_valid`, `wr_valid`, `done` and `fault` are all 0. `res_eq` is 0 and both result halves are 0.
- R2: The expected word is {`req_exp_hi`,`req_exp_lo`}, with the high half in bits 63:32. The replacement word {`req_new_hi`,`req_new_lo`} is formed the same way. The expected word is compared against all 64 bits of `rd_data`, so a difference in either half alone is a mismatch.
- R3: On a match, `wr_data` carries the replacement word, `res_eq` becomes 1 and the result halves equal the request's expected halves.
- R4: On a mismatch, `wr_data` equals the word read and `res_eq` becomes 0. `res_exp_hi` returns read bits 63:32 and `res_exp_lo` returns read bits 31:0.
- R5: A request without intercept produces exactly one read handshake and then exactly one write handshake, both at `req_addr`. The read and write valids are never high together.
- R6: With `req_lock`=1, `bus_lock` is high from the first cycle of `rd_valid` through the cycle of the write handshake, and low in DONE. With `req_lock`=0, `bus_lock` stays low.
- R7: `rd_valid` and `wr_valid` stay high, with a stable address, until their ready input is seen.
- R8: If `ext_lock_req`=1 and `icpt_en`=1 when a request is taken, no read or write valid is raised. `done` and `fault` are both 1 on the cycle after acceptance. The result halves equal the request's expected halves and `res_eq` keeps its previous value. If either input is 0, the operation runs normally with `fault`=0.
- R9: `done` is a one-cycle pulse. `res_eq` and the result halves hold their values after `done` until the next operation updates them.
- R10: `req_ready` is 1 only in IDLE. A `req_valid` raised while the unit is busy has no effect on the current operation's bus cycles or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_addr | input | ADDR_W | Word address |
| req_exp_hi | input | HALF_W | Expected value, bits 63:32 |
| req_exp_lo | input | HALF_W | Expected value, bits 31:0 |
| req_new_hi | input | HALF_W | Replacement value, bits 63:32 |
| req_new_lo | input | HALF_W | Replacement value, bits 31:0 |
| req_lock | input | 1 | Hold the bus lock over the sequence |
| icpt_en | input | 1 | Intercept enable |
| ext_lock_req | input | 1 | External atomic lock would be required |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 2*HALF_W | Read data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 2*HALF_W | Write data |
| bus_lock | output | 1 | Bus lock |
| done | output | 1 | Operation finished, one cycle |
| fault | output | 1 | Lock intercept fault for the finished operation |
| res_exp_hi | output | HALF_W | Returned expected value, high half |
| res_exp_lo | output | HALF_W | Returned expected value, low half |
| res_eq | output | 1 | Equal flag |

## Verification
The hardest condition to reach from the ports is the window between the read handshake and the write handshake while the bus delays its answers. In that window the lock must not drop and no second read may appear. The bench plays the memory itself and stalls both ready inputs for several cycles, checking `bus_lock`, the addresses and the valids on every cycle. A further test raises `req_valid` with unrelated data for the whole busy period, which shows that the running operation is unaffected. The intercept path is checked right after operations that leave the equal flag at 1 and at 0, so that keeping the flag can be told apart from clearing it.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CMP,
        ST_WRITE,
        ST_DONE
    } cas_state_e;
endpackage

// File: rtl/cas_capture.sv
// Holds the fields of an accepted request for the whole operation.
module cas_capture #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] exp_in,
    input  logic [WORD_W-1:0] new_in,
    input  logic              lock_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] exp_q,
    output logic [WORD_W-1:0] new_q,
    output logic              lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            exp_q  <= '0;
            new_q  <= '0;
            lock_q <= 1'b0;
        end else if (load) begin
            addr_q <= addr_in;
            exp_q  <= exp_in;
            new_q  <= new_in;
            lock_q <= lock_in;
        end
    end
endmodule

// File: rtl/cas_compare.sv
// Full-width compare and selection of the write-back and returned words.
module cas_compare #(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] expected,
    input  logic [WORD_W-1:0] replacement,
    input  logic [WORD_W-1:0] mem_word,
    output logic              match,
    output logic [WORD_W-1:0] store_word,
    output logic [WORD_W-1:0] return_word
);
    always_comb begin
        match       = (mem_word == expected);
        store_word  = match ? replacement : mem_word;
        return_word = match ? expected : mem_word;
    end
endmodule

// File: rtl/cas_result.sv
// Equal flag and returned halves; persists between operations.
module cas_result #(
    parameter int HALF_W = 32,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_cmp,
    input  logic              upd_icpt,
    input  logic              match,
    input  logic [WORD_W-1:0] cmp_word,
    input  logic [WORD_W-1:0] icpt_word,
    output logic              eq_q,
    output logic [HALF_W-1:0] hi_q,
    output logic [HALF_W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q <= 1'b0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (upd_cmp) begin
            eq_q <= match;
            hi_q <= cmp_word[WORD_W-1:HALF_W];
            lo_q <= cmp_word[HALF_W-1:0];
        end else if (upd_icpt) begin
            hi_q <= icpt_word[WORD_W-1:HALF_W];
            lo_q <= icpt_word[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/cas_unit.sv
module cas_unit #(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 32,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF_W-1:0] req_exp_hi,
    input  logic [HALF_W-1:0] req_exp_lo,
    input  logic [HALF_W-1:0] req_new_hi,
    input  logic [HALF_W-1:0] req_new_lo,
    input  logic              req_lock,
    input  logic              icpt_en,
    input  logic              ext_lock_req,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              bus_lock,
    output logic              done,
    output logic              fault,
    output logic [HALF_W-1:0] res_exp_hi,
    output logic [HALF_W-1:0] res_exp_lo,
    output logic              res_eq
);
    import cas_pkg::*;

    cas_state_e        state_q, state_d;
    logic              accept, icpt_hit;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] exp_q, new_q, mem_q, store_q;
    logic              lock_q, fault_q;
    logic              match;
    logic [WORD_W-1:0] store_word, return_word;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign icpt_hit = ext_lock_req && icpt_en;

    cas_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .addr_in (req_addr),
        .exp_in  ({req_exp_hi, req_exp_lo}),
        .new_in  ({req_new_hi, req_new_lo}),
        .lock_in (req_lock),
        .addr_q  (addr_q),
        .exp_q   (exp_q),
        .new_q   (new_q),
        .lock_q  (lock_q)
    );

    cas_compare #(.WORD_W(WORD_W)) u_compare (
        .expected    (exp_q),
        .replacement (new_q),
        .mem_word    (mem_q),
        .match       (match),
        .store_word  (store_word),
        .return_word (return_word)
    );

    cas_result #(.HALF_W(HALF_W)) u_result (
        .clk       (clk),
        .rst       (rst),
        .upd_cmp   (state_q == ST_CMP),
        .upd_icpt  (accept && icpt_hit),
        .match     (match),
        .cmp_word  (return_word),
        .icpt_word ({req_exp_hi, req_exp_lo}),
        .eq_q      (res_eq),
        .hi_q      (res_exp_hi),
        .lo_q      (res_exp_lo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = icpt_hit ? ST_DONE : ST_READ;
            ST_READ:  if (rd_ready) state_d = ST_CMP;
            ST_CMP:   state_d = ST_WRITE;
            ST_WRITE: if (wr_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            store_q <= '0;
            fault_q <= 1'b0;
        end else begin
            if (accept)                           fault_q <= icpt_hit;
            if (state_q == ST_READ && rd_ready)   mem_q   <= rd_data;
            if (state_q == ST_CMP)                store_q <= store_word;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        wr_valid  = 1'b0;
        bus_lock  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  begin rd_valid = 1'b1; bus_lock = lock_q; end
            ST_CMP:   bus_lock = lock_q;
            ST_WRITE: begin wr_valid = 1'b1; bus_lock = lock_q; end
            ST_DONE:  done = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign rd_addr = addr_q;
    assign wr_addr = addr_q;
    assign wr_data = store_q;
    assign fault   = fault_q && (state_q == ST_DONE);
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              bus_lock,
    input logic              done,
    input logic              fault
);
    // R5
    no_dual_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_valid));

    // R5
    no_reread_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> !rd_valid);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && !(wr_valid && wr_ready)) |=> bus_lock);

    // R6
    idle_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready || done) |-> !bus_lock);

    // R7
    rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R7
    wr_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

    // R8
    fault_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> $past(req_valid && req_ready));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind cas_unit cas_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .bus_lock  (bus_lock),
    .done      (done),
    .fault     (fault)
);

// File: tb/cas_unit_tb.sv
`timescale 1ns/1ps
module cas_unit_tb;
    localparam int AW = 32;
    localparam int HW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [HW-1:0] req_exp_hi = '0, req_exp_lo = '0, req_new_hi = '0, req_new_lo = '0;
    logic          req_lock = 1'b0, icpt_en = 1'b0, ext_lock_req = 1'b0;
    logic          rd_valid, wr_valid, bus_lock, done, fault, res_eq;
    logic          rd_ready = 1'b0, wr_ready = 1'b0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [63:0]   rd_data = '0, wr_data;
    logic [HW-1:0] res_exp_hi, res_exp_lo;

    int total = 0;
    int bad = 0;

    // observations from the last operation
    int          n_rd, n_wr;
    logic [63:0] o_wdata;
    logic        o_eq, o_fault, o_lockbad, o_addrbad, o_readybad, o_both;
    logic [63:0] o_res;

    always #4 clk = ~clk;

    cas_unit #(.ADDR_W(AW), .HALF_W(HW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_exp_hi(req_exp_hi), .req_exp_lo(req_exp_lo),
        .req_new_hi(req_new_hi), .req_new_lo(req_new_lo), .req_lock(req_lock),
        .icpt_en(icpt_en), .ext_lock_req(ext_lock_req),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_lock(bus_lock), .done(done), .fault(fault),
        .res_exp_hi(res_exp_hi), .res_exp_lo(res_exp_lo), .res_eq(res_eq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one request and plays the memory; records what it observes.
    task automatic run_op(input logic [63:0] expv, input logic [63:0] newv,
                          input logic [63:0] mem, input logic [AW-1:0] addr,
                          input logic lock, input logic icpt, input logic ext,
                          input int rdd, input int wrd, input bit noise);
        int rwait = 0;
        int wwait = 0;
        bit fin = 0;
        n_rd = 0; n_wr = 0; o_wdata = '0;
        o_lockbad = 0; o_addrbad = 0; o_readybad = 0; o_both = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        req_exp_hi = expv[63:32]; req_exp_lo = expv[31:0];
        req_new_hi = newv[63:32]; req_new_lo = newv[31:0];
        req_lock = lock; icpt_en = icpt; ext_lock_req = ext;
        for (int cyc = 0; cyc < 100 && !fin; cyc++) begin
            @(negedge clk);
            rd_ready = 1'b0; wr_ready = 1'b0;
            if (noise) begin
                req_valid = 1'b1; req_addr = ~addr;
                req_exp_hi = ~expv[63:32]; req_exp_lo = ~expv[31:0];
                req_new_hi = 32'h0; req_new_lo = 32'h0;
                req_lock = ~lock; icpt_en = 1'b1; ext_lock_req = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (req_ready) o_readybad = 1;
            if (rd_valid && wr_valid) o_both = 1;
            if (rd_valid || wr_valid || (n_rd > 0 && n_wr == 0)) begin
                if (bus_lock !== lock) o_lockbad = 1;
            end
            if (rd_valid) begin
                if (rd_addr !== addr) o_addrbad = 1;
                if (rwait >= rdd) begin
                    rd_ready = 1'b1; rd_data = mem; n_rd++;
                end else rwait++;
            end
            if (wr_valid) begin
                if (wr_addr !== addr) o_addrbad = 1;
                if (wwait >= wrd) begin
                    wr_ready = 1'b1; o_wdata = wr_data; n_wr++;
                end else wwait++;
            end
            if (done) begin
                fin = 1;
                o_eq = res_eq; o_fault = fault;
                o_res = {res_exp_hi, res_exp_lo};
                if (bus_lock) o_lockbad = 1;
                req_valid = 1'b0;
            end
        end
        if (!fin) chk(0, "R9", "watchdog: done never seen", 0, 1);
        @(negedge clk);
        chk(!done, "R9", "done lasts one cycle", {63'd0, done}, 0);
        chk(req_ready, "R10", "ready again after retire", {63'd0, req_ready}, 1);
        chk(res_eq === o_eq && {res_exp_hi, res_exp_lo} === o_res, "R9",
            "results held after done", {res_exp_hi, res_exp_lo}, o_res);
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1", "ready after reset", {63'd0, req_ready}, 1);
        chk({rd_valid, wr_valid, bus_lock, done, fault} === 5'b0, "R1", "controls idle",
            {59'd0, rd_valid, wr_valid, bus_lock, done, fault}, 0);
        chk(res_eq === 1'b0 && {res_exp_hi, res_exp_lo} === 64'd0, "R1", "results cleared",
            {res_exp_hi, res_exp_lo}, 0);
    endtask

    task automatic t_match_locked;
        logic [63:0] e = 64'h1234_5678_9ABC_DEF0;
        logic [63:0] n = 64'hCAFE_F00D_0BAD_BEEF;
        run_op(e, n, e, 32'h100, 1, 0, 0, 0, 0, 0);
        chk(o_wdata === n, "R3", "match writes replacement", o_wdata, n);
        chk(o_eq === 1'b1, "R3", "eq set on match", {63'd0, o_eq}, 1);
        chk(o_res === e, "R3", "halves unchanged on match", o_res, e);
        chk(n_rd == 1 && n_wr == 1 && !o_both, "R5", "one read then one write",
            {n_rd[31:0], n_wr[31:0]}, {32'd1, 32'd1});
        chk(!o_lockbad, "R6", "lock held read..write", {63'd0, o_lockbad}, 0);
        chk(!o_fault, "R8", "no fault without intercept", {63'd0, o_fault}, 0);
    endtask

    task automatic t_mismatch_stalled;
        logic [63:0] e = 64'h0000_0001_0000_0002;
        logic [63:0] m = 64'hFFFF_0000_AAAA_5555;
        run_op(e, 64'h0123_4567_89AB_CDEF, m, 32'h2040, 1, 0, 0, 3, 4, 0);
        chk(o_wdata === m, "R4", "mismatch writes old value back", o_wdata, m);
        chk(o_eq === 1'b0, "R4", "eq cleared on mismatch", {63'd0, o_eq}, 0);
        chk(o_res === m, "R4", "halves loaded from memory", o_res, m);
        chk(!o_addrbad, "R7", "address stable during stalls", {63'd0, o_addrbad}, 0);
        chk(!o_lockbad, "R6", "lock held across stalls", {63'd0, o_lockbad}, 0);
        chk(n_rd == 1 && n_wr == 1, "R7", "stalled handshakes counted once",
            {n_rd[31:0], n_wr[31:0]}, {32'd1, 32'd1});
    endtask

    task automatic t_unlocked;
        logic [63:0] e = 64'h5555_AAAA_5555_AAAA;
        run_op(e, 64'h1, e, 32'h8, 0, 0, 0, 1, 0, 0);
        chk(!o_lockbad, "R6", "no lock when lock flag clear", {63'd0, o_lockbad}, 0);
        chk(o_wdata === 64'h1 && o_eq, "R3", "unlocked match", o_wdata, 64'h1);
    endtask

    task automatic t_half_diff;
        logic [63:0] e = 64'hDEAD_BEEF_0000_0000;
        run_op(e, 64'h7, 64'hDEAD_BEEF_0000_0001, 32'h10, 1, 0, 0, 0, 0, 0);
        chk(o_eq === 1'b0 && o_res === 64'hDEAD_BEEF_0000_0001, "R2",
            "low-half-only difference is mismatch", o_res, 64'hDEAD_BEEF_0000_0001);
        run_op(e, 64'h7, 64'h5EAD_BEEF_0000_0000, 32'h10, 1, 0, 0, 0, 0, 0);
        chk(o_eq === 1'b0 && o_wdata === 64'h5EAD_BEEF_0000_0000, "R2",
            "high-half-only difference is mismatch", o_wdata, 64'h5EAD_BEEF_0000_0000);
    endtask

    task automatic t_intercept(input logic prev_eq);
        logic [63:0] e = 64'h0F0F_0F0F_F0F0_F0F0;
        run_op(e, 64'h9, 64'h0, 32'h300, 1, 1, 1, 0, 0, 0);
        chk(n_rd == 0 && n_wr == 0, "R8", "no bus cycle on intercept",
            {n_rd[31:0], n_wr[31:0]}, 0);
        chk(o_fault === 1'b1, "R8", "fault on intercept", {63'd0, o_fault}, 1);
        chk(o_eq === prev_eq, "R8", "eq kept on intercept", {63'd0, o_eq}, {63'd0, prev_eq});
        chk(o_res === e, "R8", "halves unchanged on intercept", o_res, e);
    endtask

    task automatic t_no_intercept_partial;
        logic [63:0] e = 64'h2;
        run_op(e, 64'h3, e, 32'h40, 1, 1, 0, 0, 0, 0);
        chk(!o_fault && n_wr == 1 && o_wdata === 64'h3, "R8", "icpt_en alone runs normally",
            o_wdata, 64'h3);
        run_op(e, 64'h4, 64'h3, 32'h40, 1, 0, 1, 0, 0, 0);
        chk(!o_fault && n_wr == 1 && o_wdata === 64'h3, "R8", "ext lock alone runs normally",
            o_wdata, 64'h3);
    endtask

    task automatic t_busy_noise;
        logic [63:0] e = 64'hAAAA_0000_BBBB_0000;
        logic [63:0] n = 64'h1111_2222_3333_4444;
        run_op(e, n, e, 32'h500, 1, 0, 0, 2, 2, 1);
        chk(!o_readybad, "R10", "ready low while busy", {63'd0, o_readybad}, 0);
        chk(o_wdata === n && o_eq && !o_fault, "R10", "busy request ignored", o_wdata, n);
        chk(!o_addrbad && !o_lockbad, "R10", "address and lock from first request",
            {62'd0, o_addrbad, o_lockbad}, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!rd_valid && !wr_valid, "R10", "no extra operation started",
                {62'd0, rd_valid, wr_valid}, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "R9", "global watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_match_locked();
        t_intercept(1'b1);
        t_mismatch_stalled();
        t_intercept(1'b0);
        t_unlocked();
        t_half_diff();
        t_no_intercept_partial();
        t_busy_noise();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule